// File: doc/BRIEF.md
# Three-Phase Signed Energy Integrator with Reversal Flag

This block turns a stream of calibrated, signed per-phase active power samples into energy for three phases. Each phase has a first-stage accumulator that sums samples as signed values. When its running sum reaches plus or minus a programmable threshold, the threshold is taken back out, the remainder is kept, and one signed energy quantum is passed to a second-stage counter. That counter steps up by one for a positive quantum and down by one for a negative quantum.

Every quantum is compared with the sign of the previous quantum on the same phase. If the sign differs, the block sets a per-phase reversal status bit and updates a per-phase sign bit. A mask register can route any status bit to an active-low interrupt. A host clears a status bit by writing one to its position. A select bit in a control register chooses whether the total-power or the fundamental-power inputs feed the accumulators.

Top module: `rev_energy_acc`

## Requirements
- R1: After reset the status bits, sign bits, accumulators and energy counters are zero and `irq_n` is high.
- R2: Samples are summed as signed values. A negative sample lowers the first-stage sum, and no quantum is emitted while the sum lies strictly between the negative and the positive threshold.
- R3: When a valid sample brings a phase's sum to the threshold or above, the threshold is subtracted, the remainder is kept, and that phase's energy counter rises by one.
- R4: When a valid sample brings a phase's sum to the negative threshold or below, the threshold is added, the remainder is kept, and that phase's energy counter falls by one. The counter wraps in two's complement.
- R5: Control bit 6 selects the input. At 0, the reset value, the total-power inputs are used. At 1, the fundamental-power inputs are used and the total-power inputs have no effect.
- R6: A quantum whose sign differs from the stored sign of its phase sets a status bit: bit 6 for phase A, bit 7 for B, bit 8 for C. The stored sign is positive after reset, so a first positive quantum raises no flag and a first negative quantum does.
- R7: Sign bits 0, 1 and 2 (phases A, B, C) change in the same cycle as the matching status bit. A value of 0 means positive and 1 means negative.
- R8: `irq_n` is low exactly when some status bit among 8..6 is set and the mask bit at the same position is also set. Unmasked status bits leave `irq_n` high.
- R9: A clear write sets each status bit whose data bit is 1 to 0. Data bits that are 0 leave their status bits unchanged. Once no masked status bit remains set, `irq_n` returns high.
- R10: When a reversal and a clear write for the same bit fall in the same cycle, the bit ends up set.
- R11: Reversal is judged only when a quantum is emitted. Samples that change sign without the sum crossing a threshold raise no flag and leave the sign bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Qualifies one sample for all three phases |
| pwr_total | input | 3*PW | Signed total active power, phase A in the low slice |
| pwr_fund | input | 3*PW | Signed fundamental active power, phase A in the low slice |
| quantum_thr | input | AW-1 | Unsigned first-stage threshold |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | RW | Control data, bit 6 selects the input source |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | RW | Mask data, bits 8..6 enable the interrupt |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | RW | Ones clear the matching status bits |
| status | output | RW | Reversal flags at bits 8..6 (C, B, A) |
| sign_flags | output | RW | Sign of the last quantum at bits 2..0 (C, B, A) |
| energy | output | 3*EW | Signed second-stage energy counters, phase A in the low slice |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A sample, a register write or a clear presented before a rising edge takes effect at that edge. The energy counters, the status bits and the sign bits are registered there, and `irq_n` is decoded combinationally from the registered status and mask, so it settles in the same cycle. The bench changes inputs on the falling edge, keeps them for one rising edge, and checks the results at the following falling edge, which is exactly one register stage after the stimulus. The expected energy values and remainders are tracked by hand from the threshold arithmetic, so each check expects a specific quantum at a specific sample.

// File: rtl/rev_energy_acc.sv
module rev_energy_acc #(
  parameter int PW       = 24,
  parameter int AW       = 28,
  parameter int EW       = 16,
  parameter int RW       = 16,
  parameter int SEL_BIT  = 6,
  parameter int STAT_LSB = 6,
  parameter int SIGN_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [3*PW-1:0]   pwr_total,
  input  logic [3*PW-1:0]   pwr_fund,
  input  logic [AW-2:0]     quantum_thr,
  input  logic              ctrl_we,
  input  logic [RW-1:0]     ctrl_wdata,
  input  logic              mask_we,
  input  logic [RW-1:0]     mask_wdata,
  input  logic              clr_we,
  input  logic [RW-1:0]     clr_wdata,
  output logic [RW-1:0]     status,
  output logic [RW-1:0]     sign_flags,
  output logic [3*EW-1:0]   energy,
  output logic              irq_n
);
  localparam int NPH = 3;

  logic [RW-1:0]        ctrl_q, mask_q;
  logic [NPH-1:0]       st_q, sgn_q, hit_pos, hit_neg, rev;
  logic signed [AW-1:0] acc_q [NPH];
  logic signed [AW:0]   sum_w [NPH];
  logic [EW-1:0]        en_q  [NPH];
  logic signed [AW:0]   thr_s;
  logic [NPH-1:0]       clr_bits, irq_bits;

  assign thr_s    = $signed({2'b00, quantum_thr});
  assign clr_bits = clr_we ? clr_wdata[STAT_LSB +: NPH] : '0;
  assign irq_bits = st_q & mask_q[STAT_LSB +: NPH];
  assign irq_n    = ~|irq_bits;

  always_comb begin
    status     = '0;
    sign_flags = '0;
    status[STAT_LSB +: NPH]     = st_q;
    sign_flags[SIGN_LSB +: NPH] = sgn_q;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic signed [PW-1:0] smp;
    assign smp        = ctrl_q[SEL_BIT] ? pwr_fund[i*PW +: PW] : pwr_total[i*PW +: PW];
    assign sum_w[i]   = (AW+1)'(acc_q[i]) + (AW+1)'(smp);
    assign hit_pos[i] = smp_valid && (sum_w[i] >= thr_s);
    assign hit_neg[i] = smp_valid && !hit_pos[i] && (sum_w[i] <= -thr_s);
    assign rev[i]     = (hit_pos[i] && sgn_q[i]) || (hit_neg[i] && !sgn_q[i]);
    assign energy[i*EW +: EW] = en_q[i];

    p_sign_moves_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sign_flags[SIGN_LSB+i]) |-> status[STAT_LSB+i]);

    p_energy_needs_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid) |-> $stable(energy[i*EW +: EW]));

    p_flag_from_quantum_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[STAT_LSB+i]) |-> $past(smp_valid) && !$stable(energy[i*EW +: EW]));

    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rev[i] |=> status[STAT_LSB+i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      st_q   <= '0;
      sgn_q  <= '0;
      for (int i = 0; i < NPH; i++) begin
        acc_q[i] <= '0;
        en_q[i]  <= '0;
      end
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (mask_we) mask_q <= mask_wdata;
      st_q <= rev | (st_q & ~clr_bits);
      for (int i = 0; i < NPH; i++) begin
        if (smp_valid) begin
          if (hit_pos[i]) begin
            acc_q[i] <= AW'(sum_w[i] - thr_s);
            en_q[i]  <= en_q[i] + 1'b1;
            sgn_q[i] <= 1'b0;
          end else if (hit_neg[i]) begin
            acc_q[i] <= AW'(sum_w[i] + thr_s);
            en_q[i]  <= en_q[i] - 1'b1;
            sgn_q[i] <= 1'b1;
          end else begin
            acc_q[i] <= AW'(sum_w[i]);
          end
        end
      end
    end
  end

  p_irq_needs_masked_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> |(status[STAT_LSB +: NPH] & mask_q[STAT_LSB +: NPH]));

endmodule

// File: tb/rev_energy_acc_bench.sv
`timescale 1ns/1ps
module rev_energy_acc_bench;
  localparam int PW = 24, AW = 28, EW = 16, RW = 16;

  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [3*PW-1:0] pwr_total = '0, pwr_fund = '0;
  logic [AW-2:0] quantum_thr = 27'd1000;
  logic ctrl_we = 1'b0, mask_we = 1'b0, clr_we = 1'b0;
  logic [RW-1:0] ctrl_wdata = '0, mask_wdata = '0, clr_wdata = '0;
  logic [RW-1:0] status, sign_flags;
  logic [3*EW-1:0] energy;
  logic irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rev_energy_acc u_rev_energy_acc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .pwr_total(pwr_total), .pwr_fund(pwr_fund), .quantum_thr(quantum_thr),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .status(status), .sign_flags(sign_flags), .energy(energy), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] en(input int ph);
    return 32'(energy[ph*EW +: EW]);
  endfunction

  // one sample on all phases; clear write may ride along
  task automatic smp(input int ta, input int tb, input int tc,
                     input int fa = 0, input int fb = 0, input int fc = 0,
                     input logic [RW-1:0] clr = '0);
    @(negedge clk);
    pwr_total = {PW'(tc), PW'(tb), PW'(ta)};
    pwr_fund  = {PW'(fc), PW'(fb), PW'(fa)};
    smp_valid = 1'b1;
    clr_we    = |clr;
    clr_wdata = clr;
    @(negedge clk);
    smp_valid = 1'b0;
    clr_we    = 1'b0;
    clr_wdata = '0;
  endtask

  task automatic wr(input int which, input logic [RW-1:0] d);
    @(negedge clk);
    ctrl_we = (which == 0); ctrl_wdata = d;
    mask_we = (which == 1); mask_wdata = d;
    clr_we  = (which == 2); clr_wdata  = d;
    @(negedge clk);
    ctrl_we = 1'b0; mask_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", 32'(status), 0);
    chk("R1 sign", 32'(sign_flags), 0);
    chk("R1 energy", 32'(energy), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
  endtask

  task automatic t_positive;
    smp(400, 0, 0); smp(400, 0, 0);
    chk("R2 below threshold", en(0), 0);
    smp(400, 0, 0);                       // 1200 -> quantum, 200 left
    chk("R3 first quantum", en(0), 1);
    chk("R6 first positive no flag", 32'(status), 0);
    smp(800, 0, 0);                       // remainder 200 + 800 reaches 1000
    chk("R3 remainder kept", en(0), 2);
  endtask

  task automatic t_signed;
    smp(500, 0, 0); smp(-300, 0, 0); smp(700, 0, 0);   // 900
    chk("R2 negative sample reduces", en(0), 2);
    smp(100, 0, 0);
    chk("R2 reaches after reduction", en(0), 3);
  endtask

  task automatic t_reversal;
    smp(0, -600, 0); smp(0, -600, 0);     // B: -1200 -> -1, -200 left
    chk("R4 negative quantum", en(1), 32'hFFFF);
    chk("R6 status B", 32'(status), 32'h0080);
    chk("R7 sign B", 32'(sign_flags), 32'h0002);
    chk("R8 unmasked irq high", 32'(irq_n), 1);
    wr(1, 16'h0080);
    chk("R8 masked irq low", 32'(irq_n), 0);
    wr(2, 16'h0040);
    chk("R9 zero bit keeps flag", 32'(status), 32'h0080);
    wr(2, 16'h0080);
    chk("R9 cleared", 32'(status), 0);
    chk("R9 irq released", 32'(irq_n), 1);
    chk("R9 sign kept", 32'(sign_flags), 32'h0002);
  endtask

  task automatic t_midstream;
    smp(0, 0, 600); smp(0, 0, -500); smp(0, 0, 600);   // C: 700, no quantum
    chk("R11 no flag without crossing", 32'(status), 0);
    chk("R11 sign unchanged", 32'(sign_flags), 32'h0002);
    smp(0, 0, 300);
    chk("R11 positive quantum C", en(2), 1);
    chk("R6 same sign no flag", 32'(status), 0);
  endtask

  task automatic t_select;
    wr(0, 16'h0040);
    smp(2000, 0, 0, -1000, 0, 0);         // A fund -1000 from 0
    chk("R5 fundamental used", en(0), 2);
    chk("R6 status A", 32'(status), 32'h0040);
    chk("R7 sign A", 32'(sign_flags), 32'h0003);
    chk("R8 A unmasked", 32'(irq_n), 1);
    smp(5000, 0, 0, 0, 0, 0);
    chk("R5 total ignored", en(0), 2);
    wr(0, 16'h0000);
    wr(2, 16'h01C0);
    smp(0, 1200, 0);                      // B: -200 + 1200 -> +1
    chk("R5 total back", en(1), 0);
    chk("R6 B back positive", 32'(status), 32'h0080);
    chk("R7 sign B positive", 32'(sign_flags), 32'h0001);
  endtask

  task automatic t_priority;
    smp(0, -1000, 0, 0, 0, 0, 16'h0080);
    chk("R10 set wins over clear", 32'(status), 32'h0080);
    chk("R10 sign B negative", 32'(sign_flags), 32'h0003);
    chk("R4 B decremented", en(1), 32'hFFFF);
    chk("R8 irq with mask", 32'(irq_n), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_positive;
    t_signed;
    t_reversal;
    t_midstream;
    t_select;
    t_priority;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule